// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Write Permission

This block caches recent virtual-to-physical page translations for 4-KiB pages. It holds 32 entries and searches all of them at once. Each entry is tagged with an address-space identifier as well as the virtual page number. Translations from several processes can therefore live side by side, and a context switch needs no flush. A lookup takes a 32-bit virtual address, an 8-bit identifier and a read/write flag. One clock later the block answers with one of three results: a 30-bit physical address with a hit flag, a miss flag that asks the requester to refill and retry, or a write-protection fault.

Refills arrive on a separate port with the page number, the identifier, the physical page number and a write-permission bit. The block picks the slot itself:
- a resident entry for the same page and identifier is overwritten;
- otherwise the lowest-numbered empty slot is used;
- otherwise the slot under a round-robin pointer is used.

Two invalidation inputs are provided. One clears every entry. The other clears only the entries of one address space. Each entry also keeps a dirty bit, which is set by the first permitted write to that page.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid: hit, miss, wrFault, dirty and physAddr are 0, and the first lookup of any address misses.
- R2: A lookup presented at a clock edge is answered at the next edge with exactly one of hit, miss or wrFault set. A hit gives physAddr = {stored 18-bit physical page, vaddr[11:0]}. With no lookup, all three flags stay 0.
- R3: An entry matches only when it is valid and both vaddr[31:12] and the identifier are equal. The same page under another identifier misses, and both address spaces may hold that page at once.
- R4: A write lookup that matches an entry whose write bit is 0 gives wrFault=1, hit=0, physAddr=0. A read of the same entry still hits.
- R5: On a permitted write hit, dirty is 1, and it stays 1 on every later hit of that entry. A read hit of an entry never written gives dirty=0. A refill clears the bit, and a faulting write does not set it.
- R6: A refill that matches no resident entry goes into the lowest-numbered invalid slot when one exists. No valid entry is evicted in that case.
- R7: The round-robin pointer starts at 0 and advances by one, modulo 32, on every refill. When no slot is invalid, the refill evicts the entry at the pointer.
- R8: A refill whose page and identifier are already resident overwrites that entry. This replaces the physical page and the write bit and never creates a duplicate.
- R9: flushAll invalidates every entry at one clock edge, so lookups in the following cycle miss.
- R10: flushAsidValid invalidates only the entries whose identifier equals flushAsid. Entries of other identifiers keep hitting.
- R11: A lookup sees the table as it was before the edge, so a lookup in the same cycle as a flush still hits. A refill in the same cycle as a flush is written and survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVaddr | input | 32 | Virtual address to translate |
| lookupAsid | input | 8 | Address-space identifier of the lookup |
| lookupWrite | input | 1 | 1 = write access, 0 = read |
| refillValid | input | 1 | Load a new entry this cycle |
| refillVpn | input | 20 | Virtual page number of the new entry |
| refillAsid | input | 8 | Identifier of the new entry |
| refillPpn | input | 18 | Physical page number of the new entry |
| refillWritable | input | 1 | Write permission of the new entry |
| flushAll | input | 1 | Invalidate all entries |
| flushAsidValid | input | 1 | Invalidate entries of one identifier |
| flushAsid | input | 8 | Identifier to invalidate |
| physAddr | output | 30 | Translated address on a hit, else 0 |
| hit | output | 1 | Lookup translated |
| miss | output | 1 | No match; refill request |
| wrFault | output | 1 | Write to a read-only page |
| dirty | output | 1 | Dirty state of the hit entry |

## Verification
The bench fills all 32 slots and then refills twice more. It checks that the victims are the slots under the pointer, which by then has wrapped past 32. An off-by-one pointer would evict a neighbour that should still hit. The bench also empties one slot with a per-identifier flush and refills it. A design that ignored the free slot would evict an entry that still hits here.

A refill of a page that is already resident checks the new physical page and the new permission. A design that made a second copy would return the ORed payload of both entries, or fault wrongly. The same-cycle flush-with-lookup and flush-with-refill cases catch a design that reads the table after the update, or that lets the flush erase a fresh refill. Writes to read-only pages are checked to leave the dirty bit clear.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes from control to the entry array, one per state change.
  typedef struct packed {
    logic fill;       // write refill data into fillSlot
    logic setDirty;   // mark the matching entry dirty
    logic flushAll;   // clear every valid bit
    logic flushAsid;  // clear valid bits of one identifier
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tlb_pkg::tlbStrobes_t  strobes,
  input  logic [IDX_W-1:0]      fillSlot,
  input  logic [VPN_W-1:0]      lookupVpn,
  input  logic [ASID_W-1:0]     lookupAsid,
  input  logic [VPN_W-1:0]      refillVpn,
  input  logic [ASID_W-1:0]     refillAsid,
  input  logic [PPN_W-1:0]      refillPpn,
  input  logic                  refillWritable,
  input  logic [ASID_W-1:0]     flushAsidVal,
  output logic                  hitAny,
  output logic [PPN_W-1:0]      hitPpn,
  output logic                  hitWritable,
  output logic                  hitDirty,
  output logic                  freeAny,
  output logic [IDX_W-1:0]      freeIdx,
  output logic                  dupAny,
  output logic [IDX_W-1:0]      dupIdx
);
  logic [ENTRIES-1:0] validQ, dirtyQ, writableQ;
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [ASID_W-1:0]  asidQ [ENTRIES];
  logic [PPN_W-1:0]   ppnQ  [ENTRIES];
  logic [ENTRIES-1:0] hitVec, dupVec, flushVec;

  // Parallel comparators, one set per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g]   = validQ[g] && vpnQ[g] == lookupVpn && asidQ[g] == lookupAsid;
    assign dupVec[g]   = validQ[g] && vpnQ[g] == refillVpn && asidQ[g] == refillAsid;
    assign flushVec[g] = strobes.flushAll || (strobes.flushAsid && asidQ[g] == flushAsidVal);
  end

  always_comb begin
    hitAny      = |hitVec;
    dupAny      = |dupVec;
    freeAny     = ~&validQ;
    hitPpn      = '0;
    hitWritable = 1'b0;
    hitDirty    = 1'b0;
    dupIdx      = '0;
    freeIdx     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        hitPpn      |= ppnQ[i];
        hitWritable |= writableQ[i];
        hitDirty    |= dirtyQ[i];
      end
      if (dupVec[i]) dupIdx |= IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) freeIdx = IDX_W'(i);
    end
  end

  // Valid and dirty state; a refill wins over a flush of the same slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobes.fill && fillSlot == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          dirtyQ[i] <= 1'b0;
        end else begin
          if (flushVec[i]) validQ[i] <= 1'b0;
          if (strobes.setDirty && hitVec[i]) dirtyQ[i] <= 1'b1;
        end
      end
    end
  end

  // Payload storage, no reset needed.
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobes.fill && fillSlot == IDX_W'(i)) begin
        vpnQ[i]      <= refillVpn;
        asidQ[i]     <= refillAsid;
        ppnQ[i]      <= refillPpn;
        writableQ[i] <= refillWritable;
      end
    end
  end

  // R8: refill steering must never leave two entries answering one lookup.
  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R9: a flush-all without a refill empties the table at the next edge.
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flushAll && !strobes.fill) |=> (validQ == '0));

  // R6: the slot named for a refill is valid afterwards.
  assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fill |=> validQ[$past(fillSlot)]);
endmodule

// File: rtl/tlb_lookup_ctrl.sv
module tlb_lookup_ctrl #(
  parameter int ENTRIES = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lookupValid,
  input  logic                  lookupWrite,
  input  logic [OFF_W-1:0]      lookupOffset,
  input  logic                  refillValid,
  input  logic                  flushAll,
  input  logic                  flushAsidValid,
  input  logic                  hitAny,
  input  logic [PPN_W-1:0]      hitPpn,
  input  logic                  hitWritable,
  input  logic                  hitDirty,
  input  logic                  freeAny,
  input  logic [IDX_W-1:0]      freeIdx,
  input  logic                  dupAny,
  input  logic [IDX_W-1:0]      dupIdx,
  output tlb_pkg::tlbStrobes_t  strobes,
  output logic [IDX_W-1:0]      fillSlot,
  output logic [PA_W-1:0]       physAddr,
  output logic                  hit,
  output logic                  miss,
  output logic                  wrFault,
  output logic                  dirty
);
  logic [IDX_W-1:0] rrPtr;
  logic grant, denied, noMatch;

  assign grant   = lookupValid && hitAny && (!lookupWrite || hitWritable);
  assign denied  = lookupValid && hitAny && lookupWrite && !hitWritable;
  assign noMatch = lookupValid && !hitAny;

  always_comb begin
    strobes.fill      = refillValid;
    strobes.setDirty  = grant && lookupWrite;
    strobes.flushAll  = flushAll;
    strobes.flushAsid = flushAsidValid;
    if (dupAny)       fillSlot = dupIdx;
    else if (freeAny) fillSlot = freeIdx;
    else              fillSlot = rrPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr    <= '0;
      hit      <= 1'b0;
      miss     <= 1'b0;
      wrFault  <= 1'b0;
      dirty    <= 1'b0;
      physAddr <= '0;
    end else begin
      if (refillValid) rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
      hit      <= grant;
      miss     <= noMatch;
      wrFault  <= denied;
      dirty    <= grant && (hitDirty || lookupWrite);
      physAddr <= grant ? {hitPpn, lookupOffset} : '0;
    end
  end

  // R2: at most one result flag per cycle.
  assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, miss, wrFault}));

  // R2: every lookup is answered at the next edge.
  assert_lookup_answered_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (hit || miss || wrFault));

  // R4: a protection fault only follows a write request.
  assert_fault_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrFault |-> $past(lookupWrite && lookupValid));

  // R5: the dirty output is only meaningful alongside a hit.
  assert_dirty_with_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    dirty |-> hit);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 18,
  parameter int ASID_W  = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic [ASID_W-1:0] lookupAsid,
  input  logic              lookupWrite,
  input  logic              refillValid,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [ASID_W-1:0] refillAsid,
  input  logic [PPN_W-1:0]  refillPpn,
  input  logic              refillWritable,
  input  logic              flushAll,
  input  logic              flushAsidValid,
  input  logic [ASID_W-1:0] flushAsid,
  output logic [PA_W-1:0]   physAddr,
  output logic              hit,
  output logic              miss,
  output logic              wrFault,
  output logic              dirty
);
  tlb_pkg::tlbStrobes_t strobes;
  logic [IDX_W-1:0] fillSlot, freeIdx, dupIdx;
  logic [PPN_W-1:0] hitPpn;
  logic hitAny, hitWritable, hitDirty, freeAny, dupAny;

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) array_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fillSlot(fillSlot),
    .lookupVpn(lookupVaddr[VA_W-1:OFF_W]), .lookupAsid(lookupAsid),
    .refillVpn(refillVpn), .refillAsid(refillAsid), .refillPpn(refillPpn),
    .refillWritable(refillWritable), .flushAsidVal(flushAsid),
    .hitAny(hitAny), .hitPpn(hitPpn), .hitWritable(hitWritable), .hitDirty(hitDirty),
    .freeAny(freeAny), .freeIdx(freeIdx), .dupAny(dupAny), .dupIdx(dupIdx)
  );

  tlb_lookup_ctrl #(.ENTRIES(ENTRIES), .OFF_W(OFF_W), .PPN_W(PPN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupOffset(lookupVaddr[OFF_W-1:0]), .refillValid(refillValid),
    .flushAll(flushAll), .flushAsidValid(flushAsidValid),
    .hitAny(hitAny), .hitPpn(hitPpn), .hitWritable(hitWritable), .hitDirty(hitDirty),
    .freeAny(freeAny), .freeIdx(freeIdx), .dupAny(dupAny), .dupIdx(dupIdx),
    .strobes(strobes), .fillSlot(fillSlot), .physAddr(physAddr),
    .hit(hit), .miss(miss), .wrFault(wrFault), .dirty(dirty)
  );
endmodule

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid, lookupWrite, refillValid, refillWritable;
  logic        flushAll, flushAsidValid;
  logic [31:0] lookupVaddr;
  logic [7:0]  lookupAsid, refillAsid, flushAsid;
  logic [19:0] refillVpn;
  logic [17:0] refillPpn;
  logic [29:0] physAddr;
  logic        hit, miss, wrFault, dirty;

  always #5 clk = ~clk;

  asid_tlb dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .lookupAsid(lookupAsid), .lookupWrite(lookupWrite), .refillValid(refillValid),
    .refillVpn(refillVpn), .refillAsid(refillAsid), .refillPpn(refillPpn),
    .refillWritable(refillWritable), .flushAll(flushAll), .flushAsidValid(flushAsidValid),
    .flushAsid(flushAsid), .physAddr(physAddr), .hit(hit), .miss(miss),
    .wrFault(wrFault), .dirty(dirty)
  );

  typedef struct packed {
    logic        eHit;
    logic        eMiss;
    logic        eFault;
    logic        eDirty;
    logic [29:0] ePa;
  } expItem_t;

  expItem_t expQ[$];
  string    reqQ[$];
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  localparam logic [7:0] ASID_A = 8'h11;
  localparam logic [7:0] ASID_B = 8'h22;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: pops one expectation per reported result.
  always @(negedge clk) begin
    if (rstN && (hit || miss || wrFault)) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R2: unexpected result hit=%0b miss=%0b flt=%0b, expected no result",
                 hit, miss, wrFault);
      end else begin
        automatic expItem_t e = expQ.pop_front();
        automatic string r = reqQ.pop_front();
        if ({hit, miss, wrFault, dirty, physAddr} !== e) begin
          mismatched++;
          $display("FAIL %s: got hit=%0b miss=%0b flt=%0b dirty=%0b pa=%h, expected hit=%0b miss=%0b flt=%0b dirty=%0b pa=%h",
                   r, hit, miss, wrFault, dirty, physAddr,
                   e.eHit, e.eMiss, e.eFault, e.eDirty, e.ePa);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      finishRun();
    end
  end

  function automatic void pushExp(logic h, logic m, logic f, logic d, logic [29:0] pa, string r);
    expQ.push_back({h, m, f, d, pa});
    reqQ.push_back(r);
  endfunction

  task automatic clearAfterEdge();
    @(posedge clk);
    #1;
    lookupValid = 0; refillValid = 0; flushAll = 0; flushAsidValid = 0; lookupWrite = 0;
  endtask

  task automatic setLookup(logic [31:0] va, logic [7:0] asid, logic wr);
    lookupValid = 1; lookupVaddr = va; lookupAsid = asid; lookupWrite = wr;
  endtask

  task automatic setRefill(logic [19:0] vpn, logic [7:0] asid, logic [17:0] ppn, logic wr);
    refillValid = 1; refillVpn = vpn; refillAsid = asid; refillPpn = ppn; refillWritable = wr;
  endtask

  task automatic lookHit(logic [31:0] va, logic [7:0] asid, logic wr, logic [17:0] ppn, logic d, string r);
    @(negedge clk);
    setLookup(va, asid, wr);
    pushExp(1, 0, 0, d, {ppn, va[11:0]}, r);
    clearAfterEdge();
  endtask

  task automatic lookMiss(logic [31:0] va, logic [7:0] asid, string r);
    @(negedge clk);
    setLookup(va, asid, 0);
    pushExp(0, 1, 0, 0, '0, r);
    clearAfterEdge();
  endtask

  task automatic lookFault(logic [31:0] va, logic [7:0] asid, string r);
    @(negedge clk);
    setLookup(va, asid, 1);
    pushExp(0, 0, 1, 0, '0, r);
    clearAfterEdge();
  endtask

  task automatic refill(logic [19:0] vpn, logic [7:0] asid, logic [17:0] ppn, logic wr);
    @(negedge clk);
    setRefill(vpn, asid, ppn, wr);
    clearAfterEdge();
  endtask

  task automatic flushId(logic [7:0] asid);
    @(negedge clk);
    flushAsidValid = 1; flushAsid = asid;
    clearAfterEdge();
  endtask

  initial begin
    rstN = 0;
    lookupValid = 0; lookupWrite = 0; refillValid = 0; refillWritable = 0;
    flushAll = 0; flushAsidValid = 0; lookupVaddr = '0; lookupAsid = '0;
    refillAsid = '0; refillVpn = '0; refillPpn = '0; flushAsid = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: quiet outputs after reset.
    compared++;
    if ({hit, miss, wrFault, dirty, physAddr} !== '0) begin
      mismatched++;
      $display("FAIL R1: reset outputs %b, expected all zero", {hit, miss, wrFault, dirty, physAddr});
    end
    lookMiss(32'h1234_5678, ASID_A, "R1");

    refill(20'h12345, ASID_A, 18'h2ABCD, 1);                  // slot 0, ptr 1
    lookHit(32'h1234_5678, ASID_A, 0, 18'h2ABCD, 0, "R2");
    lookMiss(32'h1234_5678, ASID_B, "R3");
    refill(20'h12345, ASID_B, 18'h00777, 0);                  // slot 1, ptr 2
    lookHit(32'h1234_5678, ASID_B, 0, 18'h00777, 0, "R3");
    lookHit(32'h1234_5FFF, ASID_A, 0, 18'h2ABCD, 0, "R3");

    lookFault(32'h1234_5678, ASID_B, "R4");
    lookHit(32'h1234_5678, ASID_B, 0, 18'h00777, 0, "R5 fault leaves clean");

    lookHit(32'h1234_5ABC, ASID_A, 1, 18'h2ABCD, 1, "R5 first write");
    lookHit(32'h1234_5001, ASID_A, 0, 18'h2ABCD, 1, "R5 sticky");

    refill(20'h12345, ASID_A, 18'h01111, 0);                  // dup -> slot 0, ptr 3
    lookHit(32'h1234_5678, ASID_A, 0, 18'h01111, 0, "R8 overwrite clears dirty");
    lookFault(32'h1234_5678, ASID_A, "R8 new permission");

    flushId(ASID_A);
    lookMiss(32'h1234_5678, ASID_A, "R10");
    lookHit(32'h1234_5678, ASID_B, 0, 18'h00777, 0, "R10 other id kept");

    // R11: lookup in the flush cycle sees the old table.
    @(negedge clk);
    flushAll = 1;
    setLookup(32'h1234_5678, ASID_B, 0);
    pushExp(1, 0, 0, 0, {18'h00777, 12'h678}, "R11 lookup before flush");
    clearAfterEdge();
    lookMiss(32'h1234_5678, ASID_B, "R9");

    // Fill all 32 slots; entry 10 belongs to ASID_B. Pointer ends at 3.
    for (int i = 0; i < 32; i++)
      refill(20'h40000 + 20'(i), (i == 10) ? ASID_B : ASID_A, 18'(i), 1);
    for (int i = 0; i < 32; i += 7)
      lookHit({20'h40000 + 20'(i), 12'h000}, (i == 10) ? ASID_B : ASID_A, 0, 18'(i), 0, "R6 fill order");

    refill(20'h50000, ASID_A, 18'h15000, 1);                  // evicts slot 3
    lookMiss(32'h4000_3000, ASID_A, "R7 victim at pointer");
    lookHit(32'h4000_2000, ASID_A, 0, 18'd2, 0, "R7 neighbour below");
    lookHit(32'h4000_4000, ASID_A, 0, 18'd4, 0, "R7 neighbour above");
    lookHit(32'h5000_0000, ASID_A, 0, 18'h15000, 0, "R7 new entry");
    refill(20'h50001, ASID_A, 18'h15001, 1);                  // evicts slot 4
    lookMiss(32'h4000_4000, ASID_A, "R7 pointer advanced");
    lookHit(32'h4000_5000, ASID_A, 0, 18'd5, 0, "R7 next kept");

    flushId(ASID_B);                                          // frees slot 10
    lookMiss(32'h4000_A000, ASID_B, "R10 flush by id");
    refill(20'h60000, ASID_A, 18'h16000, 1);                  // into slot 10, not 5
    lookHit(32'h4000_5000, ASID_A, 0, 18'd5, 0, "R6 free slot preferred");
    lookHit(32'h6000_0123, ASID_A, 0, 18'h16000, 0, "R6 new entry");
    lookHit(32'h4000_B000, ASID_A, 0, 18'd11, 0, "R6 other kept");

    // R11: refill in the flush cycle survives.
    @(negedge clk);
    flushAll = 1;
    setRefill(20'h70000, ASID_A, 18'h3FFFF, 1);
    clearAfterEdge();
    lookHit(32'h7000_0FFF, ASID_A, 0, 18'h3FFFF, 0, "R11 refill survives flush");
    lookMiss(32'h4000_5000, ASID_A, "R9 others flushed");

    repeat (3) @(negedge clk);
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R2: %0d lookups unanswered, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule